// File: doc/BRIEF.md
# Filter Alignment Calibration Controller

This block selects the operating state of a radio receiver front end from three active-low control strobes and, while the alignment state is selected, runs a slow up/down trimming loop that pulls the centre frequency of on-chip tunable filters onto target. A fast reference clock is turned into a periodic step enable. On every step, a one-bit comparator verdict from the analog discriminator path moves a trim code by one count, up or down. The resulting code is fanned out unchanged to three identical capacitor-array trim buses.

The trim code starts at midscale. It moves only while alignment runs, holds its value through receive and transmit, and returns to midscale whenever the sleep state is entered, so a fresh alignment is needed after every sleep. A static strap input inhibits the trimming loop entirely. All control and comparator inputs are treated as asynchronous and are synchronized before use.

Top module: `filter_trim_ctrl`

## Requirements
- R1: The control strobes pass two synchronizer flops and a decode register, so `mode` reflects a new strobe pattern three clock edges after it is applied. The encoding of `mode` is 0 = sleep, 1 = align, 2 = receive, 3 = transmit. The strobes {rx_sel_n, tx_sel_n, lo_en_n} = 110 select align, 010 select receive, 100 select transmit and 111 select sleep.
- R2: Every other strobe pattern (000, 001, 011, 101) decodes as sleep, with the same effect on the trim code as sleep.
- R3: While and after synchronous reset `rst`, `mode` is sleep, `align_active` is 0 and all trim buses hold midscale (64).
- R4: Once alignment starts running, the first trim step takes effect DIV_RATIO clock edges later, and further steps follow every DIV_RATIO edges. No step takes effect earlier.
- R5: On each step, a synchronized `cmp_hi` of 1 raises the code by one, and a 0 lowers it by one.
- R6: The code saturates: a step up at 127 leaves 127, a step down at 0 leaves 0; it never wraps.
- R7: In receive or transmit the code is frozen at its last value whatever `cmp_hi` does, and alignment resumes from that value when align is selected again.
- R8: One edge after `mode` becomes sleep, the code returns to midscale (64) and stays there until alignment runs again.
- R9: While `align_dis` is 1 the code does not move in align mode. When the strap is cleared, alignment starts running at once under R4.
- R10: The buses `trim_a`, `trim_b` and `trim_c` always carry the same code.
- R11: `align_active` is 1 exactly when `mode` is align and `align_dis` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sel_n | input | 1 | Receive select strobe, active low, asynchronous |
| tx_sel_n | input | 1 | Transmit select strobe, active low, asynchronous |
| lo_en_n | input | 1 | Local oscillator enable strobe, active low, asynchronous |
| cmp_hi | input | 1 | Comparator verdict: 1 means the centre frequency is high, asynchronous |
| align_dis | input | 1 | Static strap; 1 inhibits the trimming loop |
| mode | output | 2 | Decoded operating state (0 sleep, 1 align, 2 receive, 3 transmit) |
| align_active | output | 1 | High while the trimming loop is running |
| trim_a | output | 7 | Trim code for capacitor array A |
| trim_b | output | 7 | Trim code for capacitor array B |
| trim_c | output | 7 | Trim code for capacitor array C |

## Verification
The bench builds the block with DIV_RATIO = 4 and the default 7-bit trim width. The short step period lets the code be driven from midscale to both saturation limits and back within a few thousand cycles. At four edges it is also still longer than the three-edge decode latency, so a mode change applied just after a step takes effect before the next step can land. Random comparator verdicts are then checked step by step against a saturating model in the bench, and the freeze, sleep-reset and strap rules are checked on the same code.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_ALIGN = 2'd1,
        MODE_RX    = 2'd2,
        MODE_TX    = 2'd3
    } mode_t;

    typedef struct packed {
        logic rx_n;
        logic tx_n;
        logic lo_n;
    } ctl_t;

    // Unlisted strobe patterns fall back to the sleep state.
    function automatic mode_t decode_mode(ctl_t c);
        mode_t m;
        case ({c.rx_n, c.tx_n, c.lo_n})
            3'b110:  m = MODE_ALIGN;
            3'b010:  m = MODE_RX;
            3'b100:  m = MODE_TX;
            default: m = MODE_SLEEP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sync2.sv
module sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            out_q  <= RST_VAL;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/step_divider.sv
module step_divider #(
    parameter int DIV_RATIO = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic step_o
);
    localparam int CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt_q;

    // Held at zero while idle, so every run restarts a full period.
    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign step_o = run_i && (cnt_q == LAST);

    generate
        if (DIV_RATIO > 1) begin : g_pulse_chk
            // R4
            single_step_chk: assert property (@(posedge clk) disable iff (rst)
                step_o |=> !step_o);
        end
        if (DIV_RATIO > 2) begin : g_start_chk
            // R4
            no_early_step_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(run_i) |=> !step_o);
        end
    endgenerate
endmodule

// File: rtl/trim_counter.sv
module trim_counter
    import trim_cal_pkg::*;
#(
    parameter int TRIM_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_t             mode_i,
    input  logic              step_i,
    input  logic              up_i,
    output logic [TRIM_W-1:0] code_o
);
    localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [TRIM_W-1:0] TOP = '1;

    logic [TRIM_W-1:0] code_q;
    logic              at_top;
    logic              at_bot;

    assign at_top = (code_q == TOP);
    assign at_bot = (code_q == '0);

    always_ff @(posedge clk) begin
        if (rst || mode_i == MODE_SLEEP) begin
            code_q <= MID;
        end else if (step_i && mode_i == MODE_ALIGN) begin
            if (up_i && !at_top) begin
                code_q <= code_q + TRIM_W'(1);
            end else if (!up_i && !at_bot) begin
                code_q <= code_q - TRIM_W'(1);
            end
        end
    end

    assign code_o = code_q;

    // R6
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_ALIGN && step_i && up_i && code_q == TOP) |=> code_q == TOP);
    // R6
    bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_ALIGN && step_i && !up_i && code_q == '0) |=> code_q == '0);
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i != MODE_SLEEP && !step_i) |=> $stable(code_q));
    // R8
    sleep_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SLEEP) |=> code_q == MID);
endmodule

// File: rtl/filter_trim_ctrl.sv
module filter_trim_ctrl
    import trim_cal_pkg::*;
#(
    parameter int DIV_RATIO = 16,
    parameter int TRIM_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_sel_n,
    input  logic              tx_sel_n,
    input  logic              lo_en_n,
    input  logic              cmp_hi,
    input  logic              align_dis,
    output logic [1:0]        mode,
    output logic              align_active,
    output logic [TRIM_W-1:0] trim_a,
    output logic [TRIM_W-1:0] trim_b,
    output logic [TRIM_W-1:0] trim_c
);
    localparam int N_BUS = 3;
    localparam int SYN_W = 4;

    logic [SYN_W-1:0]  raw_in;
    logic [SYN_W-1:0]  syn_in;
    ctl_t              ctl_s;
    logic              cmp_s;
    mode_t             mode_q;
    logic              run;
    logic              step;
    logic [TRIM_W-1:0] code;
    logic [TRIM_W-1:0] trim_bus [N_BUS];

    assign raw_in = {rx_sel_n, tx_sel_n, lo_en_n, cmp_hi};

    sync2 #(
        .W       (SYN_W),
        .RST_VAL (4'b1110)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    assign ctl_s = ctl_t'(syn_in[3:1]);
    assign cmp_s = syn_in[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_SLEEP;
        end else begin
            mode_q <= decode_mode(ctl_s);
        end
    end

    assign run = (mode_q == MODE_ALIGN) && !align_dis;

    step_divider #(
        .DIV_RATIO (DIV_RATIO)
    ) i_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .step_o (step)
    );

    trim_counter #(
        .TRIM_W (TRIM_W)
    ) i_cnt (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_q),
        .step_i (step),
        .up_i   (cmp_s),
        .code_o (code)
    );

    genvar g;
    generate
        for (g = 0; g < N_BUS; g++) begin : g_fan
            assign trim_bus[g] = code;
        end
    endgenerate

    assign trim_a       = trim_bus[0];
    assign trim_b       = trim_bus[1];
    assign trim_c       = trim_bus[2];
    assign mode         = mode_q;
    assign align_active = run;

    // R9
    strap_step_chk: assert property (@(posedge clk) disable iff (rst)
        align_dis |-> !step);
    // R11
    active_mode_chk: assert property (@(posedge clk) disable iff (rst)
        align_active |-> (mode == 2'd1));
    // R10
    fan_match_chk: assert property (@(posedge clk) disable iff (rst)
        (trim_a == trim_b) && (trim_b == trim_c));
endmodule

// File: tb/test_filter_trim_ctrl.sv
module test_filter_trim_ctrl;
    localparam int DIV = 4;
    localparam int TW  = 7;
    localparam int MID = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_sel_n = 1'b1;
    logic          tx_sel_n = 1'b1;
    logic          lo_en_n = 1'b1;
    logic          cmp_hi = 1'b0;
    logic          align_dis = 1'b0;
    logic [1:0]    mode;
    logic          align_active;
    logic [TW-1:0] trim_a, trim_b, trim_c;

    int n_chk  = 0;
    int n_fail = 0;
    int expc   = MID;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    filter_trim_ctrl #(.DIV_RATIO(DIV), .TRIM_W(TW)) i_filter_trim_ctrl (
        .clk(clk), .rst(rst), .rx_sel_n(rx_sel_n), .tx_sel_n(tx_sel_n),
        .lo_en_n(lo_en_n), .cmp_hi(cmp_hi), .align_dis(align_dis),
        .mode(mode), .align_active(align_active),
        .trim_a(trim_a), .trim_b(trim_b), .trim_c(trim_c));

    // Saturating step per R5 and R6.
    function automatic int sat_step(int v, bit up);
        if (up) return (v == 127) ? 127 : v + 1;
        return (v == 0) ? 0 : v - 1;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_trim(string tag, int exp);
        check(tag, trim_a, exp);
        check("R10 trim_b", trim_b, exp);
        check("R10 trim_c", trim_c, exp);
    endtask

    // Called at a negedge; applies strobes and waits out the decode latency.
    task automatic set_mode(logic [2:0] s);
        {rx_sel_n, tx_sel_n, lo_en_n} = s;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // One step period with a given verdict, then check the code.
    task automatic one_step(bit up, string tag);
        cmp_hi = up;
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        expc = sat_step(expc, up);
        check_trim(tag, expc);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3 during reset
        check("R3 mode in reset", mode, 0);
        check_trim("R3 trim in reset", MID);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 mode", mode, 0);
        check("R3 align_active", align_active, 0);
        check_trim("R3 trim", MID);

        // R1 latency: unchanged after two edges, align after three
        {rx_sel_n, tx_sel_n, lo_en_n} = 3'b110;
        cmp_hi = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 mode before latency", mode, 0);
        @(posedge clk);
        @(negedge clk);
        check("R1 align mode", mode, 1);
        check("R11 align_active on", align_active, 1);

        // R4: no step before DIV edges, first step at DIV
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        check_trim("R4 no early step", MID);
        @(posedge clk);
        @(negedge clk);
        expc = sat_step(expc, 1'b1);
        check_trim("R4 first step", expc);

        // R5 random verdicts
        for (int i = 0; i < 40; i++) one_step(1'($urandom % 2), "R5 random step");
        // R6 saturation high then low
        for (int i = 0; i < 70; i++) one_step(1'b1, "R6 up to top");
        check("R6 at top", trim_a, 127);
        for (int i = 0; i < 135; i++) one_step(1'b0, "R6 down to bottom");
        check("R6 at bottom", trim_a, 0);
        for (int i = 0; i < 30; i++) one_step(1'($urandom % 4 != 0), "R5 biased step");

        // R7 freeze in receive, then transmit
        set_mode(3'b010);
        check("R1 receive mode", mode, 2);
        check("R11 inactive in rx", align_active, 0);
        for (int i = 0; i < 20; i++) begin
            cmp_hi = 1'($urandom % 2);
            @(posedge clk);
        end
        @(negedge clk);
        check_trim("R7 frozen in rx", expc);
        set_mode(3'b100);
        check("R1 transmit mode", mode, 3);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check_trim("R7 frozen in tx", expc);
        set_mode(3'b110);
        check_trim("R7 resumes from held", expc);
        for (int i = 0; i < 5; i++) one_step(1'b0, "R7 resume step");

        // R8 sleep returns to midscale
        {rx_sel_n, tx_sel_n, lo_en_n} = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 sleep mode", mode, 0);
        @(posedge clk);
        @(negedge clk);
        expc = MID;
        check_trim("R8 midscale on sleep", expc);
        set_mode(3'b010);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check_trim("R8 rx after sleep keeps mid", MID);

        // R2 undefined patterns act as sleep
        for (int k = 0; k < 4; k++) begin
            logic [2:0] pat;
            pat = (k == 0) ? 3'b000 : (k == 1) ? 3'b001 : (k == 2) ? 3'b011 : 3'b101;
            set_mode(3'b110);
            one_step(1'b1, "R5 pre-undefined");
            one_step(1'b1, "R5 pre-undefined");
            {rx_sel_n, tx_sel_n, lo_en_n} = pat;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R2 undefined decodes sleep", mode, 0);
            @(posedge clk);
            @(negedge clk);
            expc = MID;
            check_trim("R2 undefined resets trim", MID);
        end

        // R9 strap inhibits alignment
        set_mode(3'b111);
        align_dis = 1'b1;
        cmp_hi = 1'b1;
        set_mode(3'b110);
        check("R1 align with strap", mode, 1);
        check("R11 strap blocks active", align_active, 0);
        repeat (10 * DIV) @(posedge clk);
        @(negedge clk);
        check_trim("R9 no steps with strap", MID);
        align_dis = 1'b0;
        #0.1;
        check("R11 active after strap clear", align_active, 1);
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        check_trim("R9 no step before period", MID);
        @(posedge clk);
        @(negedge clk);
        expc = sat_step(expc, 1'b1);
        check_trim("R9 step after strap clear", expc);
        for (int i = 0; i < 10; i++) one_step(1'($urandom % 2), "R5 final random");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule